// File: doc/BRIEF.md
# Byte-Lane Merging Palette and Scroll Writer

This block takes pending memory writes one at a time and applies them to two small on-chip stores: a colour palette memory and a vertical scroll memory. Each write names its target store, a byte address, a 16-bit value and a width tag. A full-width write overwrites a whole 16-bit word. A byte-wide write touches only one half of the stored word. It reads the word back and puts in the new byte on the side that address bit 0 selects. A third tag makes the block take its data from a separate word input, the contents of the upstream queue's current write slot, and not from the entry.

After reset the block clears both memories. It then accepts entries through a single valid/ready handshake. Full-width writes complete in the cycle they are accepted, with no stall. Byte-wide writes hold ready low for one extra cycle while the read-modify-write finishes. Scroll writes that fall beyond the implemented scroll depth are dropped. Each memory has an independent read port with one cycle of latency, for observing its contents.

Top module: `pal_scroll_writer`

## Requirements
- R1: After reset, `in_ready` stays low while both memories are swept to zero; once it rises, every palette and every scroll word reads 0x0000.
- R2: An entry with tag 0 or tag 3 writes `in_val` as a whole word, and `in_ready` is high again in the cycle after acceptance.
- R3: An entry with tag 2 writes the word on `slot_val` as a whole word and ignores `in_val`.
- R4: A byte-wide entry (tag 1) with an odd address keeps the stored low byte and replaces the high byte with `in_val[7:0]`.
- R5: A byte-wide entry (tag 1) with an even address keeps the stored high byte and replaces the low byte with `in_val[7:0]`.
- R6: After a byte-wide entry is accepted, `in_ready` is low for exactly one cycle and then high again.
- R7: The scroll word index is bits 6..1 of the byte address. A scroll entry of any tag whose index is at or above `SCR_DEPTH` (default 40) changes no word.
- R8: The palette word index is the byte address shifted right by one and masked to `PAL_DEPTH` words (default 64), so address bits above that range alias.
- R9: Each read port shows the word at the index presented one clock edge earlier.
- R10: `in_sel` = 0 targets the palette memory and `in_sel` = 1 targets the scroll memory. A write to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry present |
| in_ready | output | 1 | Block can accept an entry |
| in_sel | input | 1 | Target store: 0 palette, 1 scroll |
| in_addr | input | ADDR_W | Byte address |
| in_val | input | 16 | Entry value (low byte used for byte-wide tags) |
| in_tag | input | 2 | Width tag: 0/3 full, 1 byte, 2 full from slot word |
| slot_val | input | 16 | Word at the upstream queue write slot |
| pal_rd_idx | input | log2(PAL_DEPTH) | Palette read index |
| pal_rd_data | output | 16 | Palette read data, one cycle latency |
| scr_rd_idx | input | log2(SCR_DEPTH) | Scroll read index |
| scr_rd_data | output | 16 | Scroll read data, one cycle latency |

## Verification
If the merge stage holds a stale lane select or a stale byte, the wrong half of a word changes. The read port shows this one edge after the write-back, so the bench reads a word straight after every byte merge, with a known value on both halves beforehand. A stuck or skipped stall state shows up at once as `in_ready` out of step with the one-cycle pattern. A bad range gate in the scroll path corrupts a word that is in range through index wrap-around, and the bench finds it by re-reading the whole scroll memory. A clear sweep that ends early leaves nonzero words behind, and the first full read pass after reset finds them.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_MERGE = 2'd2
  } pw_state_e;

  localparam logic [1:0] TAG_FULL = 2'd0;
  localparam logic [1:0] TAG_BYTE = 2'd1;
  localparam logic [1:0] TAG_SLOT = 2'd2;

  localparam int WORD_W = 16;
  localparam int SCR_IDX_BITS = 6;
endpackage

// File: rtl/pw_ram.sv
module pw_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_q,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_q <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/pw_decode.sv
module pw_decode #(
  parameter int ADDR_W    = 8,
  parameter int PAL_AW    = 6,
  parameter int SCR_AW    = 6,
  parameter int SCR_DEPTH = 40
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [SCR_AW-1:0] scr_idx,
  output logic              scr_ok,
  output logic              hi_lane
);
  logic [5:0] s6;

  assign s6      = addr[6:1];
  assign pal_idx = addr[PAL_AW:1];
  assign scr_idx = s6[SCR_AW-1:0];
  assign scr_ok  = ({26'b0, s6} < 32'(SCR_DEPTH));
  assign hi_lane = addr[0];

  generate
    if (ADDR_W > 7) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:7];
    end
  endgenerate
endmodule

// File: rtl/pw_merge.sv
module pw_merge (
  input  logic [15:0] old_w,
  input  logic [7:0]  nb,
  input  logic        hi,
  output logic [15:0] new_w
);
  always_comb begin
    if (hi) new_w = {nb, old_w[7:0]};
    else    new_w = {old_w[15:8], nb};
  end
endmodule

// File: rtl/pal_scroll_writer.sv
module pal_scroll_writer
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAL_DEPTH = 64,
  parameter int SCR_DEPTH = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_sel,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic [15:0]                  in_val,
  input  logic [1:0]                   in_tag,
  input  logic [15:0]                  slot_val,
  input  logic [$clog2(PAL_DEPTH)-1:0] pal_rd_idx,
  output logic [15:0]                  pal_rd_data,
  input  logic [$clog2(SCR_DEPTH)-1:0] scr_rd_idx,
  output logic [15:0]                  scr_rd_data
);
  localparam int PAL_AW = $clog2(PAL_DEPTH);
  localparam int SCR_AW = $clog2(SCR_DEPTH);
  localparam int MAX_D  = (PAL_DEPTH > SCR_DEPTH) ? PAL_DEPTH : SCR_DEPTH;
  localparam int CLR_W  = $clog2(MAX_D);
  localparam logic [CLR_W-1:0] CLR_LAST = CLR_W'(MAX_D - 1);

  pw_state_e         state;
  logic [CLR_W-1:0]  clr_cnt;
  logic              clearing;

  logic              m_scr, m_hi, m_drop;
  logic [7:0]        m_byte;
  logic [PAL_AW-1:0] m_pidx;
  logic [SCR_AW-1:0] m_sidx;

  logic [PAL_AW-1:0] d_pidx;
  logic [SCR_AW-1:0] d_sidx;
  logic              d_sok, d_hi;

  logic              accept, is_byte;
  logic [15:0]       full_word, merged, old_word;

  logic              pal_en, pal_we, scr_en, scr_we;
  logic [PAL_AW-1:0] pal_addr;
  logic [SCR_AW-1:0] scr_addr;
  logic [15:0]       pal_wd, scr_wd, pal_aq, scr_aq;

  pw_decode #(
    .ADDR_W(ADDR_W), .PAL_AW(PAL_AW), .SCR_AW(SCR_AW), .SCR_DEPTH(SCR_DEPTH)
  ) u_dec (
    .addr(in_addr), .pal_idx(d_pidx), .scr_idx(d_sidx),
    .scr_ok(d_sok), .hi_lane(d_hi)
  );

  assign clearing  = (state == ST_CLEAR);
  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign is_byte   = (in_tag == TAG_BYTE);
  assign full_word = (in_tag == TAG_SLOT) ? slot_val : in_val;
  assign old_word  = m_scr ? scr_aq : pal_aq;

  pw_merge u_mrg (.old_w(old_word), .nb(m_byte), .hi(m_hi), .new_w(merged));

  always_comb begin
    pal_en = 1'b0; pal_we = 1'b0; pal_addr = '0; pal_wd = '0;
    scr_en = 1'b0; scr_we = 1'b0; scr_addr = '0; scr_wd = '0;
    unique case (state)
      ST_CLEAR: begin
        pal_en   = ({{(32-CLR_W){1'b0}}, clr_cnt} < 32'(PAL_DEPTH));
        pal_we   = pal_en;
        pal_addr = clr_cnt[PAL_AW-1:0];
        scr_en   = ({{(32-CLR_W){1'b0}}, clr_cnt} < 32'(SCR_DEPTH));
        scr_we   = scr_en;
        scr_addr = clr_cnt[SCR_AW-1:0];
      end
      ST_IDLE: begin
        if (accept && !in_sel) begin
          pal_en   = 1'b1;
          pal_we   = !is_byte;
          pal_addr = d_pidx;
          pal_wd   = full_word;
        end
        if (accept && in_sel) begin
          scr_en   = d_sok;
          scr_we   = d_sok && !is_byte;
          scr_addr = d_sidx;
          scr_wd   = full_word;
        end
      end
      ST_MERGE: begin
        if (!m_scr) begin
          pal_en   = 1'b1;
          pal_we   = 1'b1;
          pal_addr = m_pidx;
          pal_wd   = merged;
        end else begin
          scr_en   = !m_drop;
          scr_we   = !m_drop;
          scr_addr = m_sidx;
          scr_wd   = merged;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CLEAR;
      clr_cnt <= '0;
      m_scr   <= 1'b0;
      m_hi    <= 1'b0;
      m_drop  <= 1'b0;
      m_byte  <= '0;
      m_pidx  <= '0;
      m_sidx  <= '0;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == CLR_LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept && is_byte) begin
            m_scr  <= in_sel;
            m_hi   <= d_hi;
            m_drop <= in_sel && !d_sok;
            m_byte <= in_val[7:0];
            m_pidx <= d_pidx;
            m_sidx <= d_sidx;
            state  <= ST_MERGE;
          end
        end
        ST_MERGE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  pw_ram #(.DEPTH(PAL_DEPTH), .AW(PAL_AW), .W(WORD_W)) u_pal (
    .clk(clk), .a_en(pal_en), .a_we(pal_we), .a_addr(pal_addr),
    .a_wdata(pal_wd), .a_q(pal_aq), .b_addr(pal_rd_idx), .b_q(pal_rd_data)
  );

  pw_ram #(.DEPTH(SCR_DEPTH), .AW(SCR_AW), .W(WORD_W)) u_scr (
    .clk(clk), .a_en(scr_en), .a_we(scr_we), .a_addr(scr_addr),
    .a_wdata(scr_wd), .a_q(scr_aq), .b_addr(scr_rd_idx), .b_q(scr_rd_data)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int SCR_DEPTH = 40
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sel,
  input logic [1:0] in_tag,
  input logic [5:0] widx6,
  input logic       clearing,
  input logic       pal_we,
  input logic       scr_we
);
  logic take, take_byte, scr_far;
  assign take      = in_valid && in_ready;
  assign take_byte = take && (in_tag == 2'd1);
  assign scr_far   = in_sel && ({26'b0, widx6} >= 32'(SCR_DEPTH));

  // R1: the cycle after reset is released the block is still clearing
  p_clear_stall_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !in_ready);

  // R2: full-width entries never stall
  p_full_nostall_r2: assert property (@(posedge clk) disable iff (rst)
    (take && in_tag != 2'd1) |=> in_ready);

  // R6: byte entries stall exactly one cycle
  p_byte_stall_r6: assert property (@(posedge clk) disable iff (rst)
    take_byte |=> !in_ready ##1 in_ready);

  // R7: out-of-range full scroll write leaves scroll memory alone
  p_scr_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (take && !take_byte && scr_far) |-> !scr_we);

  // R7: out-of-range byte scroll write never writes back
  p_scr_drop_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (take_byte && scr_far) |=> !scr_we);

  // R10: outside the clear sweep at most one memory is written
  p_one_mem_r10: assert property (@(posedge clk) disable iff (rst)
    !clearing |-> !(pal_we && scr_we));
endmodule

bind pal_scroll_writer pw_checker #(.SCR_DEPTH(SCR_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_sel(in_sel), .in_tag(in_tag), .widx6(in_addr[6:1]),
  .clearing(clearing), .pal_we(pal_we), .scr_we(scr_we)
);

// File: tb/sim_pal_scroll_writer.sv
module sim_pal_scroll_writer;
  localparam int ADDR_W = 8, PAL_DEPTH = 64, SCR_DEPTH = 40;
  localparam int PAL_AW = 6, SCR_AW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_sel = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [15:0] in_val = '0, slot_val = '0;
  logic [1:0] in_tag = '0;
  logic [PAL_AW-1:0] pal_rd_idx = '0;
  logic [SCR_AW-1:0] scr_rd_idx = '0;
  logic [15:0] pal_rd_data, scr_rd_data;

  int checks = 0, fails = 0;
  logic [15:0] ref_pal [PAL_DEPTH];
  logic [15:0] ref_scr [SCR_DEPTH];

  always #4 clk = ~clk;

  pal_scroll_writer #(.ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH), .SCR_DEPTH(SCR_DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_addr(in_addr), .in_val(in_val), .in_tag(in_tag),
    .slot_val(slot_val), .pal_rd_idx(pal_rd_idx), .pal_rd_data(pal_rd_data),
    .scr_rd_idx(scr_rd_idx), .scr_rd_data(scr_rd_data)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic cmp_pal(string req, int idx);
    @(negedge clk); pal_rd_idx = idx[PAL_AW-1:0];
    @(negedge clk); chk(req, $sformatf("pal[%0d]", idx), pal_rd_data, ref_pal[idx]);
  endtask

  task automatic cmp_scr(string req, int idx);
    @(negedge clk); scr_rd_idx = idx[SCR_AW-1:0];
    @(negedge clk); chk(req, $sformatf("scr[%0d]", idx), scr_rd_data, ref_scr[idx]);
  endtask

  // drives one entry, updates the model, checks handshake timing (R2, R6)
  task automatic put(bit scr, logic [7:0] addr, logic [15:0] val, logic [1:0] tag, logic [15:0] slot);
    int w, pi, si;
    logic [15:0] old, nw;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sel = scr; in_addr = addr; in_val = val;
    in_tag = tag; slot_val = slot;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    w  = int'(addr) >> 1;
    pi = w % PAL_DEPTH;
    si = w % 64;
    old = scr ? ((si < SCR_DEPTH) ? ref_scr[si] : 16'h0) : ref_pal[pi];
    if (tag == 2'd1) nw = addr[0] ? {val[7:0], old[7:0]} : {old[15:8], val[7:0]};
    else if (tag == 2'd2) nw = slot;
    else nw = val;
    if (!scr) ref_pal[pi] = nw;
    else if (si < SCR_DEPTH) ref_scr[si] = nw;
    if (tag == 2'd1) begin
      chk("R6", "ready in merge cycle", {15'b0, in_ready}, 16'd0);
      @(negedge clk);
      chk("R6", "ready after merge", {15'b0, in_ready}, 16'd1);
    end else begin
      chk("R2", "ready after full write", {15'b0, in_ready}, 16'd1);
    end
  endtask

  task automatic t_reset();
    int n = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready during clear", {15'b0, in_ready}, 16'd0);
    while (!in_ready && n < 1000) begin @(negedge clk); n++; end
    chk("R1", "ready after clear", {15'b0, in_ready}, 16'd1);
    for (int i = 0; i < PAL_DEPTH; i++) ref_pal[i] = 16'h0;
    for (int i = 0; i < SCR_DEPTH; i++) ref_scr[i] = 16'h0;
    for (int i = 0; i < PAL_DEPTH; i++) cmp_pal("R1", i);
    for (int i = 0; i < SCR_DEPTH; i++) cmp_scr("R1", i);
  endtask

  task automatic t_full();
    put(0, 8'h02, 16'h1111, 2'd0, 16'hDEAD);
    put(0, 8'h7E, 16'hF00D, 2'd3, 16'hDEAD);
    put(1, 8'h04, 16'h2222, 2'd0, 16'hBEEF);
    put(1, 8'h4E, 16'h4E4E, 2'd3, 16'hBEEF);
    cmp_pal("R2", 1); cmp_pal("R2", 63); cmp_scr("R2", 2); cmp_scr("R2", 39);
  endtask

  task automatic t_slot();
    put(0, 8'h10, 16'h0BAD, 2'd2, 16'h5A5A);
    put(1, 8'h11, 16'h0BAD, 2'd2, 16'hA5C3);
    cmp_pal("R3", 8); cmp_scr("R3", 8);
  endtask

  task automatic t_byte_odd();
    put(0, 8'h0A, 16'h1234, 2'd0, 16'h0);
    put(0, 8'h0B, 16'hFFAB, 2'd1, 16'h0);
    cmp_pal("R4", 5);
    put(1, 8'h0C, 16'h5678, 2'd0, 16'h0);
    put(1, 8'h0D, 16'h00CD, 2'd1, 16'h0);
    cmp_scr("R4", 6);
  endtask

  task automatic t_byte_even();
    put(0, 8'h20, 16'h9876, 2'd0, 16'h0);
    put(0, 8'h20, 16'hEE01, 2'd1, 16'h0);
    cmp_pal("R5", 16);
    put(1, 8'h22, 16'hAAAA, 2'd0, 16'h0);
    put(1, 8'h22, 16'h0042, 2'd1, 16'h0);
    put(1, 8'h23, 16'h0024, 2'd1, 16'h0);
    cmp_scr("R5", 17);
  endtask

  task automatic t_scr_range();
    put(1, 8'h50, 16'hBAD0, 2'd0, 16'h0);
    put(1, 8'h7F, 16'hBAD1, 2'd1, 16'h0);
    put(1, 8'h62, 16'hBAD2, 2'd2, 16'hBAD3);
    put(1, 8'hD0, 16'hBAD4, 2'd0, 16'h0);
    for (int i = 0; i < SCR_DEPTH; i++) cmp_scr("R7", i);
    put(1, 8'h86, 16'h3C3C, 2'd0, 16'h0);
    cmp_scr("R7", 3);
  endtask

  task automatic t_pal_alias();
    put(0, 8'h8A, 16'h7777, 2'd0, 16'h0);
    cmp_pal("R8", 5);
    put(0, 8'hFF, 16'h0099, 2'd1, 16'h0);
    cmp_pal("R8", 63);
  endtask

  task automatic t_readlat();
    put(0, 8'h06, 16'hA1A1, 2'd0, 16'h0);
    put(0, 8'h08, 16'hB2B2, 2'd0, 16'h0);
    @(negedge clk); pal_rd_idx = 6'd3;
    @(negedge clk);
    chk("R9", "data one edge later", pal_rd_data, 16'hA1A1);
    pal_rd_idx = 6'd4;
    #1 chk("R9", "data held until edge", pal_rd_data, 16'hA1A1);
    @(negedge clk);
    chk("R9", "new index after edge", pal_rd_data, 16'hB2B2);
  endtask

  task automatic t_one_mem();
    put(0, 8'h30, 16'h1357, 2'd0, 16'h0);
    cmp_scr("R10", 24); cmp_pal("R10", 24);
    put(1, 8'h32, 16'h2468, 2'd0, 16'h0);
    cmp_pal("R10", 25); cmp_scr("R10", 25);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    t_reset();
    t_full();
    t_slot();
    t_byte_odd();
    t_byte_even();
    t_scr_range();
    t_pal_alias();
    t_readlat();
    t_one_mem();
    repeat (4) @(negedge clk);
    report();
  end
endmodule